// File: doc/BRIEF.md
# T1/E1 Transmit Framing-Pattern Inserter

This block sits in a serial transmit path and overwrites the framing overhead bits of a T1 or E1 bit stream. It handles five formats: T1 superframe (SF), SLC-96, T1DM, T1 extended superframe (ESF) and E1. Every bit comes in on `dataIn` in a cycle where `bitEn` is high. The block keeps its own bit, frame and multiframe counters. A one-bit pulse on `mfSync` aligns those counters to the start of a multiframe. Each bit leaves on `dataOut` one enabled bit later, with any selected framing bit replaced by the value the format requires.

Two control bits select what is written. `insFrm` enables the basic framing pattern: the terminal framing bits in SF, SLC-96 and T1DM, the framing pattern sequence in ESF, and the timeslot-0 alignment words in E1. `insMf` enables the multiframe pattern: the signaling-frame bits in SF and the multiframe alignment bits in E1. Every other bit passes through unchanged. This includes ESF data-link and CRC slots, E1 Si, A and Sa bits, and the E1 CRC-report bits.

Top module: `framing_inserter`

## Requirements
- R1: While `rstN` is low, `dataOut` is 0 and the counters are cleared.
- R2: `dataOut` changes only on a clock edge where `bitEn` is high. In that cycle it takes the processed value of `dataIn`, so the latency is one enabled bit.
- R3: A bit presented with `bitEn` and `mfSync` both high is treated as bit 0 of frame 0, whatever the count was. The count then continues from bit 1 of frame 0.
- R4: With `fmtSel`=0 (SF) and `insFrm`=1, bit 0 of T1 frames 1,3,5,7,9,11 (frames counted from 1, 193 bits each) is set to 1,0,1,0,1,0.
- R5: With `fmtSel`=0 and `insMf`=1, bit 0 of frames 2,4,6,8,10,12 is set to 0,0,1,1,1,0.
- R6: With `fmtSel`=1 (SLC-96, 72-frame multiframe) or `fmtSel`=2 (T1DM, 12-frame multiframe) and `insFrm`=1, bit 0 of the odd frames alternates 1,0,1,0... starting at frame 1. `insMf` has no effect in these formats.
- R7: With `fmtSel`=3 (ESF, 24 frames) and `insFrm`=1, bit 0 of frames 4,8,12,16,20,24 is set to 0,0,1,0,1,1. Bit 0 of every other frame passes through.
- R8: With `fmtSel`=4 (E1, 256-bit frames, 16-frame multiframe, frames counted from 0) and `insFrm`=1, bits 1..7 of each even frame are set to 0,0,1,1,0,1,1. Bit 0 of an even frame passes through.
- R9: In E1 with `insFrm`=1, bit 1 of each odd frame is set to 1.
- R10: In E1 with `insMf`=1, bit 0 of odd frames 1,3,5,7,9,11 is set to 0,0,1,0,1,1. Bit 0 of frames 13 and 15 passes through.
- R11: When the enable that matches a framing position is 0, that position carries `dataIn` unchanged.
- R12: Bits that are not framing positions pass through. The counters wrap after 193 bits (T1) or 256 bits (E1) per frame, and after the multiframe length of the format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit enable; one serial bit is taken per enabled cycle |
| mfSync | input | 1 | Start-of-multiframe pulse, qualified by `bitEn` |
| dataIn | input | 1 | Serial transmit data in |
| fmtSel | input | 3 | Format: 0 SF, 1 SLC-96, 2 T1DM, 3 ESF, 4 E1 |
| insFrm | input | 1 | Enable basic framing pattern insertion |
| insMf | input | 1 | Enable multiframe pattern insertion |
| dataOut | output | 1 | Serial transmit data out with framing inserted |

## Verification
Realignment and overhead insertion can fall on the same bit. A sync pulse defines frame 0 bit 0, and in T1 that position is itself a terminal framing slot. The bench provokes this by pulsing `mfSync` in the middle of an SF frame while driving `dataIn` low. It expects the terminal framing value 1 on that bit, where the old count would have passed a payload 0. Every format is swept through a whole multiframe and on into the next under all four enable combinations, with gaps in `bitEn`, and each output bit is compared against a model computed from frame and bit arithmetic.

// File: rtl/tfi_pkg.sv
package tfi_pkg;

  typedef enum logic [2:0] {
    FMT_SF   = 3'd0,
    FMT_SLC  = 3'd1,
    FMT_T1DM = 3'd2,
    FMT_ESF  = 3'd3,
    FMT_E1   = 3'd4
  } fmtT;

  // Strobes from the counter/control side to the datapath: which overhead
  // slot the current bit occupies, and its index within the slot's pattern.
  typedef struct packed {
    logic       ftSlot;
    logic       fsSlot;
    logic       fpsSlot;
    logic       fasSlot;
    logic       nfasSlot;
    logic       mfasSlot;
    logic [2:0] idx;
  } slotT;

endpackage

// File: rtl/tfi_ctrl.sv
module tfi_ctrl
  import tfi_pkg::*;
#(
  parameter int T1_BITS = 193,
  parameter int E1_BITS = 256,
  parameter int SF_FRM  = 12,
  parameter int SLC_FRM = 72,
  parameter int DM_FRM  = 12,
  parameter int ESF_FRM = 24,
  parameter int E1_FRM  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       mfSync,
  input  logic [2:0] fmtSel,
  output slotT       slots
);

  localparam int MAX_BITS = (E1_BITS > T1_BITS) ? E1_BITS : T1_BITS;
  localparam int MAX_A    = (SLC_FRM > ESF_FRM) ? SLC_FRM : ESF_FRM;
  localparam int MAX_B    = (SF_FRM > E1_FRM) ? SF_FRM : E1_FRM;
  localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_FRM  = (MAX_C > DM_FRM) ? MAX_C : DM_FRM;
  localparam int BIT_W    = $clog2(MAX_BITS);
  localparam int FRM_W    = $clog2(MAX_FRM);

  fmtT              fmt;
  logic [BIT_W-1:0] bitCnt, curBit, lastBit;
  logic [FRM_W-1:0] frmCnt, curFrm, lastFrm;

  assign fmt    = fmtT'(fmtSel);
  assign curBit = mfSync ? '0 : bitCnt;
  assign curFrm = mfSync ? '0 : frmCnt;

  always_comb begin
    lastBit = BIT_W'(T1_BITS - 1);
    lastFrm = FRM_W'(SF_FRM - 1);
    case (fmt)
      FMT_SLC:  lastFrm = FRM_W'(SLC_FRM - 1);
      FMT_T1DM: lastFrm = FRM_W'(DM_FRM - 1);
      FMT_ESF:  lastFrm = FRM_W'(ESF_FRM - 1);
      FMT_E1: begin
        lastBit = BIT_W'(E1_BITS - 1);
        lastFrm = FRM_W'(E1_FRM - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      frmCnt <= '0;
    end else if (bitEn) begin
      if (curBit >= lastBit) begin
        bitCnt <= '0;
        frmCnt <= (curFrm >= lastFrm) ? '0 : curFrm + 1'b1;
      end else begin
        bitCnt <= curBit + 1'b1;
        frmCnt <= curFrm;
      end
    end
  end

  always_comb begin
    slots = '0;
    case (fmt)
      FMT_SF, FMT_SLC, FMT_T1DM: begin
        if (curBit == '0) begin
          slots.idx = 3'(curFrm >> 1);
          if (!curFrm[0])          slots.ftSlot = 1'b1;
          else if (fmt == FMT_SF)  slots.fsSlot = 1'b1;
        end
      end
      FMT_ESF: begin
        if (curBit == '0 && curFrm[1:0] == 2'b11) begin
          slots.fpsSlot = 1'b1;
          slots.idx     = 3'(curFrm >> 2);
        end
      end
      FMT_E1: begin
        if (!curFrm[0]) begin
          if (curBit >= BIT_W'(1) && curBit <= BIT_W'(7)) begin
            slots.fasSlot = 1'b1;
            slots.idx     = 3'(curBit - 1'b1);
          end
        end else if (curBit == BIT_W'(1)) begin
          slots.nfasSlot = 1'b1;
        end else if (curBit == '0 && curFrm <= FRM_W'(11)) begin
          slots.mfasSlot = 1'b1;
          slots.idx      = 3'(curFrm >> 1);
        end
      end
      default: ;
    endcase
  end

  // R3: a sync-qualified bit is frame 0 bit 0, so the count resumes at bit 1
  p_sync_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && mfSync) |=> (bitCnt == BIT_W'(1) && frmCnt == '0));

  // R12: the last bit of a frame wraps the bit counter to 0
  p_frame_wrap_r12: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !mfSync && bitCnt >= lastBit) |=> (bitCnt == '0));

  // R12: counters hold when no bit is taken
  p_count_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(bitCnt) && $stable(frmCnt)));

  // R8: at most one overhead slot is flagged for any bit
  p_one_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({slots.ftSlot, slots.fsSlot, slots.fpsSlot,
              slots.fasSlot, slots.nfasSlot, slots.mfasSlot}));

endmodule

// File: rtl/tfi_dpath.sv
module tfi_dpath
  import tfi_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic dataIn,
  input  logic insFrm,
  input  logic insMf,
  input  slotT slots,
  output logic dataOut
);

  // Patterns stored with pattern element 0 in bit 0.
  localparam logic [5:0] FS_PAT   = 6'b011100;  // 0,0,1,1,1,0
  localparam logic [5:0] SEQ6_PAT = 6'b110100;  // 0,0,1,0,1,1
  localparam logic [6:0] FAS_PAT  = 7'b1101100; // 0,0,1,1,0,1,1

  logic nextBit;

  always_comb begin
    nextBit = dataIn;
    if (insFrm && slots.ftSlot)   nextBit = ~slots.idx[0];
    if (insMf  && slots.fsSlot)   nextBit = FS_PAT[slots.idx];
    if (insFrm && slots.fpsSlot)  nextBit = SEQ6_PAT[slots.idx];
    if (insFrm && slots.fasSlot)  nextBit = FAS_PAT[slots.idx];
    if (insFrm && slots.nfasSlot) nextBit = 1'b1;
    if (insMf  && slots.mfasSlot) nextBit = SEQ6_PAT[slots.idx];
  end

  always_ff @(posedge clk) begin
    if (!rstN)      dataOut <= 1'b0;
    else if (bitEn) dataOut <= nextBit;
  end

  // R2: output moves only on an enabled bit
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(dataOut));

  // R11: with both enables clear every bit passes through
  p_pass_r11: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !insFrm && !insMf) |=> (dataOut == $past(dataIn)));

  // R9: the E1 odd-frame marker bit leaves as 1
  p_nfas_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && insFrm && slots.nfasSlot) |=> dataOut);

endmodule

// File: rtl/framing_inserter.sv
module framing_inserter
  import tfi_pkg::*;
#(
  parameter int T1_BITS = 193,
  parameter int E1_BITS = 256,
  parameter int SF_FRM  = 12,
  parameter int SLC_FRM = 72,
  parameter int DM_FRM  = 12,
  parameter int ESF_FRM = 24,
  parameter int E1_FRM  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       mfSync,
  input  logic       dataIn,
  input  logic [2:0] fmtSel,
  input  logic       insFrm,
  input  logic       insMf,
  output logic       dataOut
);

  slotT slots;

  tfi_ctrl #(
    .T1_BITS(T1_BITS), .E1_BITS(E1_BITS), .SF_FRM(SF_FRM), .SLC_FRM(SLC_FRM),
    .DM_FRM(DM_FRM), .ESF_FRM(ESF_FRM), .E1_FRM(E1_FRM)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .mfSync(mfSync),
    .fmtSel(fmtSel), .slots(slots)
  );

  tfi_dpath uDpath (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .dataIn(dataIn),
    .insFrm(insFrm), .insMf(insMf), .slots(slots), .dataOut(dataOut)
  );

  // R1: output is 0 in the cycle after a reset cycle
  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> !dataOut);

endmodule

// File: tb/tb_framing_inserter.sv
module tb_framing_inserter;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       mfSync = 1'b0;
  logic       dataIn = 1'b0;
  logic [2:0] fmtSel = 3'd0;
  logic       insFrm = 1'b0;
  logic       insMf = 1'b0;
  logic       dataOut;

  int nChecks = 0;
  int nFails = 0;
  int bPos = 0;
  int fPos = 0;
  logic lastOut = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  framing_inserter dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .mfSync(mfSync), .dataIn(dataIn),
    .fmtSel(fmtSel), .insFrm(insFrm), .insMf(insMf), .dataOut(dataOut)
  );

  function automatic int frameLen(int f);
    return (f == 4) ? 256 : 193;
  endfunction

  function automatic int mfLen(int f);
    case (f)
      1: return 72;
      3: return 24;
      4: return 16;
      default: return 12;
    endcase
  endfunction

  function automatic logic expBit(int f, bit iF, bit iM, int fr, int b,
                                  logic d, output string tag);
    bit [0:5] fsP  = 6'b001110;
    bit [0:5] seqP = 6'b001011;
    bit [0:6] fasP = 7'b0011011;
    int n;
    logic e;
    e = d;
    tag = "R12";
    if (f < 4) begin
      if (b == 0) begin
        n = fr + 1;
        if (f == 3) begin
          if (n % 4 == 0) begin
            tag = "R11";
            if (iF) begin tag = "R7"; e = seqP[n/4 - 1]; end
          end else tag = "R7";
        end else if (n % 2 == 1) begin
          tag = "R11";
          if (iF) begin tag = (f == 0) ? "R4" : "R6"; e = (((n - 1) / 2) % 2 == 0); end
        end else if (f == 0) begin
          tag = "R11";
          if (iM) begin tag = "R5"; e = fsP[n/2 - 1]; end
        end else tag = "R6";
      end
    end else begin
      if (fr % 2 == 0) begin
        if (b >= 1 && b <= 7) begin
          tag = "R11";
          if (iF) begin tag = "R8"; e = fasP[b - 1]; end
        end else if (b == 0) tag = "R8";
      end else begin
        if (b == 1) begin
          tag = "R11";
          if (iF) begin tag = "R9"; e = 1'b1; end
        end else if (b == 0) begin
          if (fr <= 11) begin
            tag = "R11";
            if (iM) begin tag = "R10"; e = seqP[(fr - 1) / 2]; end
          end else tag = "R10";
        end
      end
    end
    return e;
  endfunction

  task automatic check(bit ok, string tag, logic act, logic exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: dataOut=%0b expected %0b (fmt %0d frame %0d bit %0d)",
               tag, act, exp, fmtSel, fPos, bPos);
    end
  endtask

  task automatic step(logic en, logic sync, logic din);
    int cb, cf;
    logic e;
    string tag;
    @(negedge clk);
    bitEn = en; mfSync = sync; dataIn = din;
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (en) begin
      cb = sync ? 0 : bPos;
      cf = sync ? 0 : fPos;
      e = expBit(int'(fmtSel), insFrm, insMf, cf, cb, din, tag);
      if (sync) tag = {"R3 ", tag};
      bPos = cb; fPos = cf;
      check(dataOut === e, tag, dataOut, e);
      bPos = cb + 1;
      if (bPos >= frameLen(int'(fmtSel))) begin
        bPos = 0;
        fPos = (cf + 1) % mfLen(int'(fmtSel));
      end
    end else begin
      check(dataOut === lastOut, "R2", dataOut, lastOut);
    end
    lastOut = dataOut;
  endtask

  function automatic logic nextData();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int total;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check(dataOut === 1'b0, "R1", dataOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    lastOut = 1'b0;
    for (int f = 0; f < 5; f++) begin
      for (int c = 0; c < 4; c++) begin
        fmtSel = 3'(f);
        insFrm = c[0];
        insMf  = c[1];
        total = frameLen(f) * mfLen(f) + 300;
        for (int i = 0; i < total; i++) begin
          if (i % 11 == 5) step(1'b0, 1'b0, nextData());
          step(1'b1, (i == 0), nextData());
        end
        step(1'b0, 1'b0, 1'b0);
      end
    end
    // Sync mid-frame in SF: the realigned bit becomes the frame-1 F bit (R3)
    fmtSel = 3'd0; insFrm = 1'b1; insMf = 1'b1;
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 1000; i++) step(1'b1, 1'b0, nextData());
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 2400; i++) step(1'b1, 1'b0, nextData());
    // Same in E1 with a 0 on the aligned bit (Si passes through)
    fmtSel = 3'd4;
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 700; i++) step(1'b1, 1'b0, nextData());
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 600; i++) step(1'b1, 1'b0, nextData());
    step(1'b0, 1'b0, 1'b0);
    // Reset returns output to 0 (R1)
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(dataOut === 1'b0, "R1", dataOut, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule